// File: doc/BRIEF.md
# Addressed serial frame receiver

This block sits behind a byte-wide UART receiver and turns the byte stream into frames for one node on a shared serial line. A frame opens with the sync pair 0x5B then 0xAD, carries a destination address, a payload whose last byte is an XOR check byte, and closes with the end pair 0xA4 then 0x52. Frames for another address are skipped, and a 0xA4 that is not followed by 0x52 counts as ordinary data.

When a frame addressed to this node closes, the block checks it. A frame that checks out and carries payload raises a one-cycle ready strobe together with its length, and the bytes stay readable through an index port. A frame that checks out and holds only the check byte raises a status-query request. A frame that fails the check raises a negative-reply request with its reply code. Bit-level sampling and the reply transmitter are handled outside this block.

Top module: `frame_rx`

## Requirements
- R1: After synchronous reset the receiver waits for a sync pair, and all three request strobes are low.
- R2: A frame starts only when 0x5B is followed by 0xAD as the next valid byte; any other second byte (including a repeated 0x5B) drops the receiver back to waiting, and the bytes that follow are ignored until a new sync pair.
- R3: The byte after the sync pair is the destination address. If it differs from NODE_ADDR the frame is skipped up to the pair 0xA4 0x52 with no strobe and no change to the stored bytes; a 0xA4 followed by any byte other than 0x52 keeps skipping.
- R4: Inside an addressed frame, a 0xA4 followed by a byte other than 0x52 is data: both bytes are stored and included in the check.
- R5: The check value starts as the address and folds in every stored byte. When 0x52 follows 0xA4, the 0xA4 is removed from the count and from the check. If the check is then zero and the remaining count, check byte included, is 2 or more, `pay_ready` pulses for one cycle, in the cycle after the clock edge that takes the 0x52, with `pay_len` equal to that count minus one.
- R6: Stored byte i (payload byte i at index i, first payload byte at index 0, the check byte just after the last payload byte) is readable at `rd_byte` for `rd_idx` = i, and stays unchanged while no byte arrives.
- R7: A frame that passes the check with a count of less than 2 (only the check byte) pulses `status_req` and not `pay_ready`.
- R8: A frame that fails the check pulses `nak_req`, with `nak_code` equal to 0xFF in that cycle.
- R9: When the stored byte count reaches MAX_BYTES (20) before the frame closes, the frame is dropped with no strobe and the receiver waits for a new sync pair; a frame with 17 payload bytes still completes.
- R10: The three strobes are each one cycle wide and never high together.
- R11: Cycles with `in_valid` low have no effect; a frame spread out with idle cycles between bytes gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe: `in_byte` holds a received byte |
| in_byte | input | 8 | Received byte |
| rd_idx | input | IW (5) | Index of the stored byte to read |
| rd_byte | output | 8 | Stored byte at `rd_idx` (0 beyond the buffer) |
| pay_ready | output | 1 | Good frame with payload has closed |
| pay_len | output | CW (5) | Payload length, check byte excluded |
| status_req | output | 1 | Request to send the status reply |
| nak_req | output | 1 | Request to send the negative reply |
| nak_code | output | 8 | Reply code for `nak_req` |

## Verification
Good frames of three payload bytes tell apart a correct byte store and length from an off-by-one on either, and a payload holding 0xA4 followed by data shows whether the end-marker lookahead restores the collecting state. A lone check byte, a corrupted check byte and a frame for another address separate the status, negative-reply and skip paths, with the stored bytes read back to show the skipped frame left them alone. Broken sync pairs and frames of 17 and 18 payload bytes pin the start condition and the exact overflow limit, and a frame with idle gaps shows that only valid bytes move the receiver.

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter logic [7:0] NODE_ADDR = 8'h01,
  parameter int MAX_BYTES = 20,
  localparam int IW = $clog2(MAX_BYTES),
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic          pay_ready,
  output logic [CW-1:0] pay_len,
  output logic          status_req,
  output logic          nak_req,
  output logic [7:0]    nak_code
);
  localparam logic [7:0] SYNC_A = 8'h5B;
  localparam logic [7:0] SYNC_B = 8'hAD;
  localparam logic [7:0] TAIL_A = 8'hA4;
  localparam logic [7:0] TAIL_B = 8'h52;

  typedef enum logic [2:0] {
    WAIT, GOT_A, GET_ADDR, TAKE, TAIL_CHK, SKIP, SKIP_TAIL
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [7:0]    chk;
  logic [7:0]    mem [MAX_BYTES];

  wire [CW-1:0] cnt_nxt = cnt + CW'(1);
  wire          full    = (cnt_nxt == CW'(MAX_BYTES));
  wire          storing = in_valid && (st == TAKE || (st == TAIL_CHK && in_byte != TAIL_B));
  wire          closing = in_valid && st == TAIL_CHK && in_byte == TAIL_B;
  wire          chk_ok  = ((chk ^ TAIL_A) == 8'h00);

  assign rd_byte = (32'(rd_idx) < MAX_BYTES) ? mem[rd_idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (storing)
      mem[cnt[IW-1:0]] <= in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= WAIT;
      cnt        <= '0;
      chk        <= '0;
      pay_ready  <= 1'b0;
      pay_len    <= '0;
      status_req <= 1'b0;
      nak_req    <= 1'b0;
      nak_code   <= 8'h00;
    end else begin
      pay_ready  <= 1'b0;
      status_req <= 1'b0;
      nak_req    <= 1'b0;
      nak_code   <= 8'h00;
      if (in_valid) begin
        case (st)
          WAIT:      st <= (in_byte == SYNC_A) ? GOT_A : WAIT;
          GOT_A:     st <= (in_byte == SYNC_B) ? GET_ADDR : WAIT;
          GET_ADDR:
            if (in_byte == NODE_ADDR) begin
              st  <= TAKE;
              cnt <= '0;
              chk <= in_byte;
            end else begin
              st <= SKIP;
            end
          SKIP:      st <= (in_byte == TAIL_A) ? SKIP_TAIL : SKIP;
          SKIP_TAIL: st <= (in_byte == TAIL_B) ? WAIT : SKIP;
          TAKE, TAIL_CHK:
            if (closing) begin
              st <= WAIT;
              if (chk_ok) begin
                if (cnt < CW'(3)) status_req <= 1'b1;
                else begin
                  pay_ready <= 1'b1;
                  pay_len   <= cnt - CW'(2);
                end
              end else begin
                nak_req  <= 1'b1;
                nak_code <= 8'hFF;
              end
            end else begin
              cnt <= cnt_nxt;
              chk <= chk ^ in_byte;
              if (full)                                   st <= WAIT;
              else if (st == TAKE && in_byte == TAIL_A)   st <= TAIL_CHK;
              else                                        st <= TAKE;
            end
          default:   st <= WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
  parameter int MAX_BYTES = 20,
  parameter int IW = 5,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [7:0]    in_byte,
  input logic [IW-1:0] rd_idx,
  input logic [7:0]    rd_byte,
  input logic          pay_ready,
  input logic [CW-1:0] pay_len,
  input logic          status_req,
  input logic          nak_req,
  input logic [7:0]    nak_code
);
  wire any_req = pay_ready | status_req | nak_req;

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({pay_ready, status_req, nak_req}) <= 1);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    any_req |=> !any_req);

  assert_needs_byte_R11: assert property (@(posedge clk) disable iff (rst)
    any_req |-> $past(in_valid));

  assert_closed_by_tail_R5: assert property (@(posedge clk) disable iff (rst)
    any_req |-> $past(in_byte) == 8'h52);

  assert_len_range_R5: assert property (@(posedge clk) disable iff (rst)
    pay_ready |-> (pay_len >= CW'(1) && 32'(pay_len) <= MAX_BYTES - 3));

  assert_nak_code_R8: assert property (@(posedge clk) disable iff (rst)
    nak_req |-> nak_code == 8'hFF);

  assert_buf_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && $stable(rd_idx)) |-> $stable(rd_byte));
endmodule

bind frame_rx frame_rx_chk #(.MAX_BYTES(MAX_BYTES), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
  .rd_idx(rd_idx), .rd_byte(rd_byte), .pay_ready(pay_ready),
  .pay_len(pay_len), .status_req(status_req), .nak_req(nak_req),
  .nak_code(nak_code)
);

// File: tb/sim_frame_rx.sv
module sim_frame_rx;
  localparam int CLK_NS = 10;
  localparam logic [7:0] ME = 8'h01;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [4:0] rd_idx = '0;
  logic [7:0] rd_byte;
  logic       pay_ready;
  logic [4:0] pay_len;
  logic       status_req;
  logic       nak_req;
  logic [7:0] nak_code;

  frame_rx #(.NODE_ADDR(ME)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .rd_idx(rd_idx), .rd_byte(rd_byte), .pay_ready(pay_ready),
    .pay_len(pay_len), .status_req(status_req), .nak_req(nak_req),
    .nak_code(nak_code)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int n_pay, n_stat, n_nak;
  logic [4:0] seen_len;
  logic [7:0] seen_code;
  logic [7:0] pl [0:31];

  always @(posedge clk) begin
    if (!rst) begin
      if (pay_ready)  begin n_pay++;  seen_len = pay_len; end
      if (status_req) n_stat++;
      if (nak_req)    begin n_nak++;  seen_code = nak_code; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(negedge clk);
    n_pay = 0; n_stat = 0; n_nak = 0; seen_len = '0; seen_code = '0;
  endtask

  task automatic put(input logic [7:0] b, input int gap = 0);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h00;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] addr, input int n, input bit spoil, input int gap = 0);
    logic [7:0] p;
    p = addr;
    put(8'h5B, gap); put(8'hAD, gap); put(addr, gap);
    for (int i = 0; i < n; i++) begin
      put(pl[i], gap);
      p ^= pl[i];
    end
    put(spoil ? (p ^ 8'h01) : p, gap);
    put(8'hA4, gap); put(8'h52, gap);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_back(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_idx = 5'(i);
      #1;
      chk(rd_byte == pl[i], req, rd_byte, pl[i]);
    end
  endtask

  task automatic t_reset();
    chk(!pay_ready && !status_req && !nak_req, "R1", {pay_ready, status_req, nak_req}, 0);
  endtask

  task automatic t_good();
    clear_counts();
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
    frame(ME, 3, 0);
    chk(n_pay == 1, "R5", n_pay, 1);
    chk(seen_len == 5'd3, "R5", seen_len, 3);
    chk(n_stat + n_nak == 0, "R10", n_stat + n_nak, 0);
    read_back(3, "R6");
  endtask

  task automatic t_foreign();
    clear_counts();
    put(8'h5B); put(8'hAD); put(8'h02); put(8'h77);
    put(8'hA4); put(8'h33); put(8'hA4); put(8'h52);
    repeat (3) @(negedge clk);
    chk(n_pay + n_stat + n_nak == 0, "R3", n_pay + n_stat + n_nak, 0);
    read_back(3, "R3");
    pl[0] = 8'h44; pl[1] = 8'h55; pl[2] = 8'h66;
    frame(ME, 3, 0);
    chk(n_pay == 1 && seen_len == 5'd3, "R3", n_pay, 1);
  endtask

  task automatic t_tail_as_data();
    clear_counts();
    pl[0] = 8'hA4; pl[1] = 8'h07; pl[2] = 8'h55;
    frame(ME, 3, 0);
    chk(n_pay == 1, "R4", n_pay, 1);
    chk(seen_len == 5'd3, "R4", seen_len, 3);
    read_back(3, "R4");
  endtask

  task automatic t_status();
    clear_counts();
    frame(ME, 0, 0);
    chk(n_stat == 1, "R7", n_stat, 1);
    chk(n_pay == 0, "R7", n_pay, 0);
  endtask

  task automatic t_nak();
    clear_counts();
    pl[0] = 8'h11; pl[1] = 8'h22;
    frame(ME, 2, 1);
    chk(n_nak == 1, "R8", n_nak, 1);
    chk(seen_code == 8'hFF, "R8", seen_code, 8'hFF);
    chk(n_pay + n_stat == 0, "R8", n_pay + n_stat, 0);
  endtask

  task automatic t_sync();
    clear_counts();
    put(8'h5B); put(8'h5B); put(8'hAD); put(ME);
    put(ME); put(8'hA4); put(8'h52);
    put(8'h5B); put(8'h00); put(ME); put(ME); put(8'hA4); put(8'h52);
    repeat (3) @(negedge clk);
    chk(n_pay + n_stat + n_nak == 0, "R2", n_pay + n_stat + n_nak, 0);
  endtask

  task automatic t_limit();
    clear_counts();
    for (int i = 0; i < 18; i++) pl[i] = 8'(8'h10 + i);
    frame(ME, 17, 0);
    chk(n_pay == 1 && seen_len == 5'd17, "R9", seen_len, 17);
    read_back(17, "R9");
    clear_counts();
    frame(ME, 18, 0);
    chk(n_pay + n_stat + n_nak == 0, "R9", n_pay + n_stat + n_nak, 0);
    pl[0] = 8'h21; pl[1] = 8'h42;
    frame(ME, 2, 0);
    chk(n_pay == 1 && seen_len == 5'd2, "R9", seen_len, 2);
  endtask

  task automatic t_gaps();
    clear_counts();
    pl[0] = 8'h5A; pl[1] = 8'h6B;
    frame(ME, 2, 0, 3);
    chk(n_pay == 1 && seen_len == 5'd2, "R11", seen_len, 2);
    read_back(2, "R11");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good();
    t_foreign();
    t_tail_as_data();
    t_status();
    t_nak();
    t_sync();
    t_limit();
    t_gaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule